// File: doc/BRIEF.md
# DS3 Line Maintenance Signal Detector

This block watches a DS3 M-frame bit stream that an upstream framer has already aligned, and reports the line's maintenance conditions as level status bits. Every received bit arrives with a tag that says whether it is payload or an overhead bit (F, M, X, P or C) and in which subframe it lies. From these the block recognises the alarm indication signal and the idle signal. It tells them apart by the repeating payload pattern and by which C bits are zero. It also flags the remote yellow alarm carried in the X bits and declares out-of-frame from windowed F-bit and M-bit error counts.

A second input carries the undecoded line bits, taken before B3ZS decoding. A run of consecutive zeros on that input raises an internal loss-of-signal flag. The loss-of-signal output combines this flag with an external active-low indication. The block does not decode line codes and does not search for framing. Its out-of-frame flag is sticky until the framer reports that it is back in frame.

Top module: `ds3_maint_mon`

## Requirements
- R1: After every M-frame that follows the first frame end seen after reset, `xyel` is 1 when both X bits of that frame are 0, and 0 otherwise. It changes only in the cycle after a frame-end bit.
- R2: Tag codes: 0 payload, 1 F, 2 M, 3 X, 4 P, 5 C. Subframes are numbered 1 to 7. X1 and X2 sit in subframes 1 and 2, and P1 and P2 in subframes 3 and 4. `ais` becomes 1 after a frame that meets all of these conditions: every payload bit differs from the one before it, the frame has no F or M error, both P bits equal the XOR of all payload bits of the previous frame, X1 equals X2, and every C bit is 0. After any other evaluated frame it becomes 0.
- R3: `idle` becomes 1 after a frame that meets all of these conditions: every payload bit differs from the payload bit two before it (1100 in any phase), framing, parity and X rules hold as in R2, and the C bits of subframe 3 are 0, whatever the other C bits are. After any other evaluated frame it becomes 0. `ais` and `idle` are never both 1.
- R4: `ais` and `idle` change only in the cycle after a frame-end bit. The first two frame ends after reset are not evaluated, because the first frame is partial and the second only supplies the parity reference. Payload pattern checks restart at every frame start.
- R5: Within each subframe the four F bits are expected to read 1,0,0,1, counted from the subframe's first F bit. `oof` becomes 1 when 3 of the last F_WIN (16) F bits are in error. Three errors spread further apart than that window do not set it.
- R6: The M bits of subframes 5, 6 and 7 are expected to read 0,1,0. `oof` becomes 1 when 2 of the last 3 frames contain an M-bit error. F and M errors count only after the first frame end.
- R7: `oof` stays 1 until `inframe_stb` is seen. The strobe clears `oof` and both error histories, and it wins over a detection in the same cycle.
- R8: The internal loss flag sets after exactly LOS_ZEROS consecutive zeros on `raw_bit` (strobed by `raw_vld`; cycles without the strobe neither count nor break the run). It clears on the first raw one.
- R9: `los` is 1 when the internal loss flag is set or `ext_los_n` is 0.
- R10: While reset is held and right after it, `ais`, `idle`, `xyel` and `oof` are 0, and `los` follows only `ext_los_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A framed bit is present |
| bit_val | input | 1 | Framed bit value |
| bit_kind | input | 3 | Tag: 0 payload, 1 F, 2 M, 3 X, 4 P, 5 C |
| sub_idx | input | 3 | Subframe number 1 to 7 |
| frm_end | input | 1 | Marks the last bit of an M-frame |
| inframe_stb | input | 1 | Framer reports in-frame; clears out-of-frame |
| raw_vld | input | 1 | Undecoded line bit present |
| raw_bit | input | 1 | Undecoded line bit |
| ext_los_n | input | 1 | External loss of signal, active low |
| ais | output | 1 | Alarm indication signal detected |
| idle | output | 1 | Idle signal detected |
| xyel | output | 1 | X-bit remote yellow |
| oof | output | 1 | Out of frame |
| los | output | 1 | Loss of signal |

## Verification
The bench builds the block with LOS_ZEROS set to 24, which makes the exact zero-run boundary (23 zeros clear, 24 set) cheap to reach. The F and M window parameters keep their defaults of 16 and 3, so the bench tests the same error ratios that the line uses. The bench frames carry only four payload bits per block. The block reads tags rather than bit positions, so each M-frame is 280 cycles long, and sequences of many frames (hysteresis, 2-of-3 M windows, F errors straddling frames) fit in a short run.

// File: rtl/ds3_maint_mon.sv
module ds3_maint_mon #(
  parameter int LOS_ZEROS = 175,
  parameter int F_WIN     = 16,
  parameter int F_LIM     = 3,
  parameter int M_WIN     = 3,
  parameter int M_LIM     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_val,
  input  logic [2:0] bit_kind,
  input  logic [2:0] sub_idx,
  input  logic       frm_end,
  input  logic       inframe_stb,
  input  logic       raw_vld,
  input  logic       raw_bit,
  input  logic       ext_los_n,
  output logic       ais,
  output logic       idle,
  output logic       xyel,
  output logic       oof,
  output logic       los
);
  localparam int LW = $clog2(LOS_ZEROS + 1);
  localparam logic [LW-1:0] ZLIM  = LW'(LOS_ZEROS);
  localparam logic [LW-1:0] ZLIM1 = LW'(LOS_ZEROS - 1);
  localparam logic [2:0] K_PAY = 3'd0, K_F = 3'd1, K_M = 3'd2,
                         K_X = 3'd3, K_P = 3'd4, K_C = 3'd5;

  logic [1:0] fr_seen;
  logic       started;
  logic [1:0] f_pos, f_pos_now;
  logic [2:0] f_sub;
  logic [1:0] p_h;
  logic [1:0] p_n;
  logic       fr_fbad, fr_mbad, fr_alt_bad, fr_idl_bad, fr_c_any, fr_c3_any;
  logic       x1, x2, pb1, pb2, par_acc, prev_par;
  logic [F_WIN-1:0] f_hist;
  logic [M_WIN-2:0] m_hist;
  logic [LW-1:0] z_cnt;
  logic          los_int;

  wire is_pay = bit_vld && bit_kind == K_PAY;
  wire is_f   = bit_vld && bit_kind == K_F;
  wire is_m   = bit_vld && bit_kind == K_M;
  wire is_x   = bit_vld && bit_kind == K_X;
  wire is_p   = bit_vld && bit_kind == K_P;
  wire is_c   = bit_vld && bit_kind == K_C;
  wire eof    = bit_vld && frm_end;

  assign started   = fr_seen != 2'd0;
  assign f_pos_now = (f_sub == sub_idx) ? f_pos : 2'd0;

  wire f_exp   = (f_pos_now == 2'd0) || (f_pos_now == 2'd3);
  wire f_err   = is_f && started && (bit_val != f_exp);
  wire m_err   = is_m && started && (sub_idx >= 3'd5) && (bit_val != (sub_idx == 3'd6));
  wire alt_bad = is_pay && (p_n != 2'd0) && (bit_val == p_h[0]);
  wire idl_bad = is_pay && (p_n == 2'd2) && (bit_val == p_h[1]);
  wire c_one   = is_c && bit_val;

  wire tot_f   = fr_fbad | f_err;
  wire tot_m   = fr_mbad | m_err;
  wire tot_alt = fr_alt_bad | alt_bad;
  wire tot_idl = fr_idl_bad | idl_bad;
  wire tot_c   = fr_c_any | c_one;
  wire tot_c3  = fr_c3_any | (c_one && sub_idx == 3'd3);
  wire par_now = par_acc ^ (is_pay & bit_val);
  wire x1_now  = (is_x && sub_idx == 3'd1) ? bit_val : x1;
  wire x2_now  = (is_x && sub_idx == 3'd2) ? bit_val : x2;
  wire pb1_now = (is_p && sub_idx == 3'd3) ? bit_val : pb1;
  wire pb2_now = (is_p && sub_idx == 3'd4) ? bit_val : pb2;

  wire common_ok = !tot_f && !tot_m && (pb1_now == prev_par) &&
                   (pb2_now == prev_par) && (x1_now == x2_now);
  wire ais_frm   = common_ok && !tot_alt && !tot_c;
  wire idl_frm   = common_ok && !tot_idl && !tot_c3;

  wire [F_WIN-1:0] f_win_next = {f_hist[F_WIN-2:0], f_err};
  wire [M_WIN-1:0] m_win_next = {m_hist, tot_m};
  wire f_trip = $countones(f_win_next) >= F_LIM;
  wire m_trip = $countones(m_win_next) >= M_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_seen <= '0; f_pos <= '0; f_sub <= '0; p_h <= '0; p_n <= '0;
      fr_fbad <= 1'b0; fr_mbad <= 1'b0; fr_alt_bad <= 1'b0; fr_idl_bad <= 1'b0;
      fr_c_any <= 1'b0; fr_c3_any <= 1'b0;
      x1 <= 1'b1; x2 <= 1'b1; pb1 <= 1'b0; pb2 <= 1'b0;
      par_acc <= 1'b0; prev_par <= 1'b0;
      ais <= 1'b0; idle <= 1'b0; xyel <= 1'b0;
    end else begin
      if (is_f) begin
        f_pos <= f_pos_now + 2'd1;
        f_sub <= sub_idx;
      end
      if (eof) begin
        p_n <= '0;
        fr_fbad <= 1'b0; fr_mbad <= 1'b0; fr_alt_bad <= 1'b0; fr_idl_bad <= 1'b0;
        fr_c_any <= 1'b0; fr_c3_any <= 1'b0;
        x1 <= 1'b1; x2 <= 1'b1; par_acc <= 1'b0;
        if (fr_seen != 2'd2) fr_seen <= fr_seen + 2'd1;
        if (started) begin
          prev_par <= par_now;
          xyel     <= ~x1_now & ~x2_now;
        end
        if (fr_seen == 2'd2) begin
          ais  <= ais_frm;
          idle <= idl_frm;
        end
      end else if (bit_vld) begin
        if (is_pay) begin
          p_h <= {p_h[0], bit_val};
          if (p_n != 2'd2) p_n <= p_n + 2'd1;
        end
        fr_fbad <= tot_f; fr_mbad <= tot_m;
        fr_alt_bad <= tot_alt; fr_idl_bad <= tot_idl;
        fr_c_any <= tot_c; fr_c3_any <= tot_c3;
        x1 <= x1_now; x2 <= x2_now; pb1 <= pb1_now; pb2 <= pb2_now;
        par_acc <= par_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof <= 1'b0; f_hist <= '0; m_hist <= '0;
    end else if (inframe_stb) begin
      oof <= 1'b0; f_hist <= '0; m_hist <= '0;
    end else begin
      if (is_f) begin
        f_hist <= f_win_next;
        if (f_trip) oof <= 1'b1;
      end
      if (eof && started) begin
        m_hist <= m_win_next[M_WIN-2:0];
        if (m_trip) oof <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z_cnt <= '0; los_int <= 1'b0;
    end else if (raw_vld) begin
      if (raw_bit) begin
        z_cnt <= '0; los_int <= 1'b0;
      end else if (z_cnt != ZLIM) begin
        z_cnt <= z_cnt + 1'b1;
        if (z_cnt == ZLIM1) los_int <= 1'b1;
      end
    end
  end

  assign los = los_int | ~ext_los_n;

  p_xyel_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xyel) |-> $past(eof));
  p_pat_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ais) || !$stable(idle)) |-> $past(eof));
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ais && idle));
  p_oof_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inframe_stb |=> !oof);
  p_oof_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> $past(inframe_stb));
  p_los_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_int) |-> $past(raw_vld && !raw_bit));
  p_los_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_int) |-> $past(raw_vld && raw_bit));
endmodule

// File: tb/ds3_maint_mon_tb.sv
`timescale 1ns/1ps
module ds3_maint_mon_tb;
  localparam int PAYB = 4;
  localparam int LZ   = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_val = 0, frm_end = 0, inframe_stb = 0;
  logic [2:0] bit_kind = 0, sub_idx = 0;
  logic raw_vld = 0, raw_bit = 0, ext_los_n = 1;
  logic ais, idle, xyel, oof, los;

  int tests = 0, fails = 0, gph = 0;
  logic prev_par = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ds3_maint_mon #(.LOS_ZEROS(LZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_kind(bit_kind), .sub_idx(sub_idx), .frm_end(frm_end),
    .inframe_stb(inframe_stb), .raw_vld(raw_vld), .raw_bit(raw_bit),
    .ext_los_n(ext_los_n), .ais(ais), .idle(idle), .xyel(xyel),
    .oof(oof), .los(los));

  // pmode(0 alt,1 1100,2 ones), cmode(0 zero,1 sub3 zero,2 ones),
  // xmode(0 both1,1 both0,2 unequal), pbad, fbad, mbad, exp ais, idle, xyel
  localparam int NV = 13;
  localparam int VEC [NV][9] = '{
    '{0,0,0,0,0,0, 1,0,0},
    '{0,0,1,0,0,0, 1,0,1},
    '{0,0,2,0,0,0, 0,0,0},
    '{0,1,0,0,0,0, 0,0,0},
    '{1,1,0,0,0,0, 0,1,0},
    '{1,0,0,0,0,0, 0,1,0},
    '{1,2,0,0,0,0, 0,0,0},
    '{0,0,0,1,0,0, 0,0,0},
    '{0,0,0,0,0,0, 1,0,0},
    '{0,0,0,0,1,0, 0,0,0},
    '{0,0,0,0,0,1, 0,0,0},
    '{2,0,0,0,0,0, 0,0,0},
    '{1,1,1,0,0,0, 0,1,1}};

  task automatic check(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] k, input logic [2:0] s, input logic v, input logic e);
    @(negedge clk);
    bit_vld = 1; bit_kind = k; sub_idx = s; bit_val = v; frm_end = e;
  endtask

  task automatic gap();
    @(negedge clk);
    bit_vld = 0; frm_end = 0; raw_vld = 0; inframe_stb = 0;
  endtask

  task automatic send_frame(input int pm, input int cm, input int xm,
                            input int pb, input int fb, input int mb);
    logic par;
    logic v;
    par = 1'b0;
    for (int s = 1; s <= 7; s++) begin
      for (int b = 0; b < 8; b++) begin
        if (b == 0) begin
          if (s <= 2) begin
            v = (xm == 0) ? 1'b1 : (xm == 1) ? 1'b0 : (s == 1);
            put(3'd3, 3'(s), v, 1'b0);
          end else if (s <= 4) begin
            put(3'd4, 3'(s), prev_par ^ (pb != 0), 1'b0);
          end else begin
            v = (s == 6) ^ (mb != 0 && s == 5);
            put(3'd2, 3'(s), v, 1'b0);
          end
        end else if (b % 2 == 1) begin
          v = (b == 1 || b == 7);
          if (s == 1 && (b - 1) / 2 < fb) v = ~v;
          put(3'd1, 3'(s), v, 1'b0);
        end else begin
          v = (cm == 0) ? 1'b0 : (cm == 1) ? (s != 3) : 1'b1;
          put(3'd5, 3'(s), v, 1'b0);
        end
        for (int p = 0; p < PAYB; p++) begin
          v = (pm == 0) ? ~gph[0] : (pm == 1) ? ~gph[1] : 1'b1;
          gph++;
          par ^= v;
          put(3'd0, 3'(s), v, (s == 7 && b == 7 && p == PAYB - 1));
        end
      end
    end
    prev_par = par;
    gap();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_vld = 0; frm_end = 0; raw_vld = 0; inframe_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    prev_par = 1'b0;
  endtask

  task automatic raw_send(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raw_vld = 1; raw_bit = v;
    end
    gap();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R10 ais", ais, 0); check("R10 idle", idle, 0);
    check("R10 xyel", xyel, 0); check("R10 oof", oof, 0); check("R10 los", los, 0);

    send_frame(0,0,0,0,0,0);
    check("R4 first frame", ais, 0);
    send_frame(0,0,0,0,0,0);
    check("R4 second frame", ais, 0);

    for (int i = 0; i < NV; i++) begin
      send_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);
      check($sformatf("R2 ais row %0d", i), ais, VEC[i][6]);
      check($sformatf("R3 idle row %0d", i), idle, VEC[i][7]);
      check($sformatf("R1 xyel row %0d", i), xyel, VEC[i][8]);
    end
    check("R5 R6 no false oof", oof, 0);

    do_reset();
    send_frame(0,0,0,0,0,0);
    send_frame(0,0,0,0,3,0);
    check("R5 three F errors", oof, 1);
    send_frame(0,0,0,0,0,0);
    check("R7 oof sticky", oof, 1);
    @(negedge clk); inframe_stb = 1;
    gap();
    check("R7 strobe clears", oof, 0);
    send_frame(0,0,0,0,2,0);
    check("R5 two F errors", oof, 0);
    send_frame(0,0,0,0,1,0);
    check("R5 errors beyond window", oof, 0);

    do_reset();
    send_frame(0,0,0,0,0,0);
    send_frame(0,0,0,0,0,1);
    send_frame(0,0,0,0,0,0);
    check("R6 one M error", oof, 0);
    send_frame(0,0,0,0,0,1);
    check("R6 two of three", oof, 1);

    do_reset();
    send_frame(0,0,0,0,0,0);
    send_frame(0,0,0,0,0,1);
    send_frame(0,0,0,0,0,0);
    send_frame(0,0,0,0,0,0);
    send_frame(0,0,0,0,0,1);
    check("R6 errors three frames apart", oof, 0);

    do_reset();
    raw_send(1'b0, LZ - 1);
    check("R8 one short of run", los, 0);
    raw_send(1'b0, 1);
    check("R8 run complete", los, 1);
    raw_send(1'b1, 1);
    check("R8 first one clears", los, 0);
    @(negedge clk); ext_los_n = 0;
    #1 check("R9 external low", los, 1);
    @(negedge clk); ext_los_n = 1;
    #1 check("R9 external high", los, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule